// File: doc/BRIEF.md
# Privilege and Feature Mode Decoder

This block condenses the processor's status word, two configuration words, a page-grain word, the debug-mode bit and a handful of implementation straps into one registered set of execution-mode flags. Downstream pipeline and memory logic read the flags instead of decoding raw control bits each cycle.

The decoder first works out the effective privilege level. Exception level, error level and debug mode each force kernel. Several flags are then derived from that effective level rather than from the raw status field.

All outputs come from one flag register. A change on any input shows at the outputs after the next rising clock edge. The block has no data stream, so all pins are plain control and status signals with no handshake.

Top module: `priv_mode_decoder`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), the outputs show kernel privilege (`priv_lvl` = 2'b00) with `cop0_ok` = 1, and every other flag is 0.
- R2: Each output reflects the inputs sampled at the most recent rising clock edge. An input change does not reach the outputs before that edge.
- R3: `priv_lvl` equals status bits [4:3] when status bit 1, status bit 2 and `dbg_mode` are all 0. Otherwise it is 2'b00 (kernel). The codes are kernel = 00, supervisor = 01 and user = 10; the raw value 11 is passed through unchanged.
- R4: `cop0_ok` is 1 when the effective level is kernel, or when status bit 28 is set and `strap_pre_r6` is 1.
- R5: `fpu_ok` follows status bit 29, and `fpr64` follows status bit 26.
- R6: `rixi_on` is 1 when the effective level is not kernel and bit 6 of the config-5 word is set.
- R7: `dsp_on` is status bit 24 ANDed with (`strap_dsp` OR `strap_dsp2`). `dsp2_on` is status bit 24 ANDed with `strap_dsp2`.
- R8: `vec_on` is `strap_vec` ANDed with bit 27 of the config-5 word.
- R9: `xpa_on` is bit 7 of the config-3 word ANDed with bit 29 of the page-grain word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_word | input | 32 | Processor status word |
| cfg5_word | input | 32 | Config-5 word |
| cfg3_word | input | 32 | Config-3 word |
| pgrain_word | input | 32 | Page-grain word |
| dbg_mode | input | 1 | Debug mode active |
| strap_pre_r6 | input | 1 | Implementation predates release 6 |
| strap_dsp | input | 1 | DSP option present |
| strap_dsp2 | input | 1 | Second-revision DSP option present |
| strap_vec | input | 1 | Vector extension present |
| priv_lvl | output | 2 | Effective privilege level |
| cop0_ok | output | 1 | Coprocessor-0 access granted |
| fpu_ok | output | 1 | FPU usable |
| fpr64 | output | 1 | 64-bit FPU register mode |
| dsp_on | output | 1 | DSP enabled |
| dsp2_on | output | 1 | Second-revision DSP enabled |
| vec_on | output | 1 | Vector extension enabled |
| rixi_on | output | 1 | Read/execute-inhibit enforced |
| xpa_on | output | 1 | Extended physical addressing enabled |

## Verification
The assertions compare each registered flag with the input values one edge earlier. They therefore assume that all inputs are synchronous to `clk` and settle before each rising edge. They also take the straps as ordinary inputs that may change at any edge, and do not rely on the straps holding still. The stimulus applies every new input set on the falling edge, including the strap bits, which change freely in the random phase. Each result is read half a period after the capturing edge, which keeps the stimulus inside those assumptions.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int WORD_W = 32;

  localparam logic [1:0] PRIV_KERN = 2'b00;
  localparam logic [1:0] PRIV_SUPV = 2'b01;
  localparam logic [1:0] PRIV_USER = 2'b10;

  // status-word bit positions
  localparam int ST_EXL  = 1;
  localparam int ST_ERL  = 2;
  localparam int ST_KSU  = 3;
  localparam int ST_MX   = 24;
  localparam int ST_FR   = 26;
  localparam int ST_CU0  = 28;
  localparam int ST_CU1  = 29;
  // config / page-grain positions
  localparam int C5_RIXI = 6;
  localparam int C5_VEC  = 27;
  localparam int C3_LPA  = 7;
  localparam int PG_ELPA = 29;

  typedef struct packed {
    logic [1:0] priv;
    logic       cop0_ok;
    logic       fpu_ok;
    logic       fpr64;
    logic       dsp_on;
    logic       dsp2_on;
    logic       vec_on;
    logic       rixi_on;
    logic       xpa_on;
  } mode_flags_t;

  localparam int FLAG_W = $bits(mode_flags_t);

  localparam mode_flags_t FLAGS_RESET = '{
    priv: PRIV_KERN, cop0_ok: 1'b1, fpu_ok: 1'b0, fpr64: 1'b0,
    dsp_on: 1'b0, dsp2_on: 1'b0, vec_on: 1'b0, rixi_on: 1'b0, xpa_on: 1'b0
  };
endpackage

// File: rtl/pmd_priv_resolve.sv
module pmd_priv_resolve
  import pmd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] status_word,
  input  logic         dbg_mode,
  output logic [1:0]   eff_priv
);
  logic forced_kernel;

  always_comb begin
    forced_kernel = status_word[ST_EXL] | status_word[ST_ERL] | dbg_mode;
    eff_priv      = forced_kernel ? PRIV_KERN : status_word[ST_KSU +: 2];
  end
endmodule

// File: rtl/pmd_feature_decode.sv
module pmd_feature_decode
  import pmd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [1:0]   eff_priv,
  input  logic [W-1:0] status_word,
  input  logic [W-1:0] cfg5_word,
  input  logic [W-1:0] cfg3_word,
  input  logic [W-1:0] pgrain_word,
  input  logic         strap_pre_r6,
  input  logic         strap_dsp,
  input  logic         strap_dsp2,
  input  logic         strap_vec,
  output mode_flags_t  flags
);
  logic in_kernel;

  always_comb begin
    in_kernel     = (eff_priv == PRIV_KERN);
    flags.priv    = eff_priv;
    flags.cop0_ok = in_kernel | (status_word[ST_CU0] & strap_pre_r6);
    flags.fpu_ok  = status_word[ST_CU1];
    flags.fpr64   = status_word[ST_FR];
    flags.dsp_on  = status_word[ST_MX] & (strap_dsp | strap_dsp2);
    flags.dsp2_on = status_word[ST_MX] & strap_dsp2;
    flags.vec_on  = strap_vec & cfg5_word[C5_VEC];
    flags.rixi_on = ~in_kernel & cfg5_word[C5_RIXI];
    flags.xpa_on  = cfg3_word[C3_LPA] & pgrain_word[PG_ELPA];
  end
endmodule

// File: rtl/pmd_flag_reg.sv
module pmd_flag_reg #(
  parameter int           W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST;
    else        q <= d;
  end
endmodule

// File: rtl/priv_mode_decoder.sv
module priv_mode_decoder
  import pmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] status_word,
  input  logic [WORD_W-1:0] cfg5_word,
  input  logic [WORD_W-1:0] cfg3_word,
  input  logic [WORD_W-1:0] pgrain_word,
  input  logic              dbg_mode,
  input  logic              strap_pre_r6,
  input  logic              strap_dsp,
  input  logic              strap_dsp2,
  input  logic              strap_vec,
  output logic [1:0]        priv_lvl,
  output logic              cop0_ok,
  output logic              fpu_ok,
  output logic              fpr64,
  output logic              dsp_on,
  output logic              dsp2_on,
  output logic              vec_on,
  output logic              rixi_on,
  output logic              xpa_on
);
  logic [1:0]  eff_priv;
  mode_flags_t next_flags;
  mode_flags_t cur_flags;

  pmd_priv_resolve #(.W(WORD_W)) u_priv (
    .status_word (status_word),
    .dbg_mode    (dbg_mode),
    .eff_priv    (eff_priv)
  );

  pmd_feature_decode #(.W(WORD_W)) u_feat (
    .eff_priv     (eff_priv),
    .status_word  (status_word),
    .cfg5_word    (cfg5_word),
    .cfg3_word    (cfg3_word),
    .pgrain_word  (pgrain_word),
    .strap_pre_r6 (strap_pre_r6),
    .strap_dsp    (strap_dsp),
    .strap_dsp2   (strap_dsp2),
    .strap_vec    (strap_vec),
    .flags        (next_flags)
  );

  pmd_flag_reg #(.W(FLAG_W), .RST(FLAGS_RESET)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (next_flags),
    .q     (cur_flags)
  );

  assign priv_lvl = cur_flags.priv;
  assign cop0_ok  = cur_flags.cop0_ok;
  assign fpu_ok   = cur_flags.fpu_ok;
  assign fpr64    = cur_flags.fpr64;
  assign dsp_on   = cur_flags.dsp_on;
  assign dsp2_on  = cur_flags.dsp2_on;
  assign vec_on   = cur_flags.vec_on;
  assign rixi_on  = cur_flags.rixi_on;
  assign xpa_on   = cur_flags.xpa_on;

  // Exception, error level or debug at the previous edge forces kernel.
  p_forced_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_word[ST_EXL] | status_word[ST_ERL] | dbg_mode)) |-> (priv_lvl == PRIV_KERN));

  p_kernel_has_cop0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_lvl == PRIV_KERN) |-> cop0_ok);

  p_fpu_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_ok |-> $past(status_word[ST_CU1]));

  p_rixi_nonkernel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rixi_on |-> (priv_lvl != PRIV_KERN));

  p_dsp2_implies_dsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dsp2_on |-> dsp_on);

  p_vec_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_on |-> $past(strap_vec & cfg5_word[C5_VEC]));

  p_xpa_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xpa_on |-> $past(cfg3_word[C3_LPA] & pgrain_word[PG_ELPA]));
endmodule

// File: tb/priv_mode_decoder_tb_top.sv
module priv_mode_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] status_word = '0, cfg5_word = '0, cfg3_word = '0, pgrain_word = '0;
  logic        dbg_mode = 1'b0, strap_pre_r6 = 1'b0, strap_dsp = 1'b0, strap_dsp2 = 1'b0, strap_vec = 1'b0;
  logic [1:0]  priv_lvl;
  logic        cop0_ok, fpu_ok, fpr64, dsp_on, dsp2_on, vec_on, rixi_on, xpa_on;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  priv_mode_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .status_word(status_word), .cfg5_word(cfg5_word),
    .cfg3_word(cfg3_word), .pgrain_word(pgrain_word), .dbg_mode(dbg_mode),
    .strap_pre_r6(strap_pre_r6), .strap_dsp(strap_dsp), .strap_dsp2(strap_dsp2),
    .strap_vec(strap_vec), .priv_lvl(priv_lvl), .cop0_ok(cop0_ok), .fpu_ok(fpu_ok),
    .fpr64(fpr64), .dsp_on(dsp_on), .dsp2_on(dsp2_on), .vec_on(vec_on),
    .rixi_on(rixi_on), .xpa_on(xpa_on)
  );

  // expected vector: {priv[1:0], cop0, fpu, fpr64, dsp, dsp2, vec, rixi, xpa}
  function automatic logic [9:0] model(input logic [31:0] st, c5, c3, pg,
                                       input logic dbg, pre6, d1, d2, vx);
    logic [1:0] p;
    p = (st[1] | st[2] | dbg) ? 2'b00 : st[4:3];
    return {p, (p == 2'b00) | (st[28] & pre6), st[29], st[26],
            st[24] & (d1 | d2), st[24] & d2, vx & c5[27],
            (p != 2'b00) & c5[6], c3[7] & pg[29]};
  endfunction

  function automatic logic [9:0] observed();
    return {priv_lvl, cop0_ok, fpu_ok, fpr64, dsp_on, dsp2_on, vec_on, rixi_on, xpa_on};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [9:0] e);
    logic [9:0] o;
    o = observed();
    chk("R3 priv", {30'd0, o[9:8]}, {30'd0, e[9:8]});
    chk("R4 cop0", {31'd0, o[7]}, {31'd0, e[7]});
    chk("R5 fpu/fpr64", {30'd0, o[6:5]}, {30'd0, e[6:5]});
    chk("R7 dsp", {30'd0, o[4:3]}, {30'd0, e[4:3]});
    chk("R8 vec", {31'd0, o[2]}, {31'd0, e[2]});
    chk("R6 rixi", {31'd0, o[1]}, {31'd0, e[1]});
    chk("R9 xpa", {31'd0, o[0]}, {31'd0, e[0]});
  endtask

  // drive on falling edge, check half a period after the capturing edge
  task automatic apply(input logic [31:0] st, c5, c3, pg,
                       input logic dbg, pre6, d1, d2, vx, input bit lat);
    logic [9:0] prev;
    @(negedge clk);
    prev = observed();
    status_word = st; cfg5_word = c5; cfg3_word = c3; pgrain_word = pg;
    dbg_mode = dbg; strap_pre_r6 = pre6; strap_dsp = d1; strap_dsp2 = d2; strap_vec = vx;
    if (lat) begin
      #2;
      chk("R2 no early change", {22'd0, observed()}, {22'd0, prev});
    end
    @(posedge clk); #10;
    check_all(model(st, c5, c3, pg, dbg, pre6, d1, d2, vx));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    process::self().srandom(32'h5EED_1234);
    // R1: reset values, with inputs driving non-reset values
    status_word = 32'hFFFF_FFE0 | 32'h18; cfg5_word = '1; cfg3_word = '1; pgrain_word = '1;
    strap_dsp = 1; strap_dsp2 = 1; strap_vec = 1;
    repeat (3) @(posedge clk);
    #10;
    chk("R1 reset flags", {22'd0, observed()}, {22'd0, 10'b00_1000_0000});
    @(negedge clk); rst_n = 1'b1;

    // R3 user mode passes through, R6 rixi in user
    apply(32'h0000_0010, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1);
    // R3 supervisor
    apply(32'h0000_0008, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1);
    // R3 EXL forces kernel; R6 rixi off
    apply(32'h0000_0012, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1);
    // R3 ERL forces kernel
    apply(32'h0000_0014, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1);
    // R3 debug forces kernel
    apply(32'h0000_0010, 32'h40, 0, 0, 1, 0, 0, 0, 0, 1);
    // R3 raw 11 passes through
    apply(32'h0000_0018, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R4 user with CU0 pre-r6 -> granted, release 6 -> denied
    apply(32'h1000_0010, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    apply(32'h1000_0010, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R5 fpu and fpr64
    apply(32'h2400_0000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R7 dsp options
    apply(32'h0100_0000, 0, 0, 0, 0, 0, 1, 0, 0, 1);
    apply(32'h0100_0000, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    apply(32'h0100_0000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R8 vector strap gating
    apply(0, 32'h0800_0000, 0, 0, 0, 0, 0, 0, 1, 1);
    apply(0, 32'h0800_0000, 0, 0, 0, 0, 0, 0, 0, 1);
    // R9 both bits needed
    apply(0, 0, 32'h80, 32'h2000_0000, 0, 0, 0, 0, 0, 1);
    apply(0, 0, 32'h80, 0, 0, 0, 0, 0, 0, 1);

    // random mix, all requirements against the model
    for (int i = 0; i < 400; i++) begin
      st = $urandom();
      if (($urandom() % 2) == 0) st[2:1] = 2'b00;
      apply(st, $urandom(), $urandom(), $urandom(), ($urandom() % 4) == 0,
            1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()), (i % 8) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule